// File: doc/BRIEF.md
# CAN message ID acceptance filter

This block decides whether a received CAN frame is kept, based on its identifier alone. It holds two independent lists of filter elements in one internal word memory: a list for 11-bit base-format identifiers and a list for 29-bit extended-format identifiers. Each list has its own element count, supplied on input ports. Software loads the elements through a simple write port. That port is honoured only while the configuration-permit input is high.

When an identifier arrives with its valid strobe, the format flag selects one of the two lists. A controller then walks that list from element 0 upward, testing one element per clock, and stops at the first hit. It reports three things with a one-cycle done pulse: whether the frame is accepted, the index of the element that hit, and that element's 3-bit action code (code 4 asks for the frame to be marked high priority). If no element hits before the list size is reached, the frame is rejected.

The controller has three states, named `S_IDLE`, `S_SCAN` and `S_DONE`. Its transitions are:
- START: from `S_IDLE` to `S_SCAN`, taken on a valid strobe.
- HIT: from `S_SCAN` to `S_DONE`, taken when the element under test matches.
- EXHAUST: from `S_SCAN` to `S_DONE`, taken when the index reaches the list size.
- NEXT: from `S_SCAN` back to `S_SCAN`, which steps the index.
- RETIRE: from `S_DONE` to `S_IDLE`, taken unconditionally.

Top module: `can_id_filter`

## Requirements
- R1: After reset, `done`, `accept`, `match_idx` and `match_cfg` are all zero, and every memory word is zero.
- R2: A write stores `wr_data` at `wr_addr` only when `wr_en` and `cfg_permit` are both high at the clock edge. A write with `cfg_permit` low leaves the memory unchanged.
- R3: Base element n is the word at address n. Its fields are: bits [31:30] type, bits [29:27] action code, bits [26:16] filter ID, and bits [10:0] mask. It hits when the type is 2 and (rx_id[10:0] & mask) equals (filter ID & mask).
- R4: Extended element n is the pair of words at addresses STD_MAX+2n and STD_MAX+2n+1. The first word holds the action code in [31:29] and the filter ID in [28:0]. The second word holds the type in [31:30] and the mask in [28:0]. The element hits when the type is 2 and (rx_id & mask) equals (filter ID & mask) over 29 bits.
- R5: An element whose type is not 2 never hits.
- R6: Elements are tested in rising index order. The reported element is the lowest-indexed hit.
- R7: When no element below the list size hits, the result is rejected: `accept`, `match_idx` and `match_cfg` are all 0. A list size of 0 rejects every identifier.
- R8: Let the capture edge be the edge on which `id_valid` is sampled in `S_IDLE`. For a hit at index n, `done` is high during the cycle after edge capture+1+n. For a reject with list size c, it is high during the cycle after edge capture+1+c. `done` lasts exactly one cycle, and the result outputs hold until the next done pulse.
- R9: `id_ide` = 0 selects the base list, sized by `std_count`. `id_ide` = 1 selects the extended list, sized by `ext_count`. The counts are sampled at the capture edge and clamped to STD_MAX (128) and EXT_MAX (64).
- R10: An `id_valid` strobe that arrives while the filter is in `S_SCAN` or `S_DONE` is ignored.
- R11: On a hit, `match_cfg` carries the action code of the element that hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_permit | input | 1 | Enables filter memory writes |
| wr_en | input | 1 | Filter memory write strobe |
| wr_addr | input | 8 | Filter memory word address |
| wr_data | input | 32 | Filter memory write data |
| std_count | input | 8 | Base-format list size |
| ext_count | input | 7 | Extended-format list size |
| id_valid | input | 1 | Received identifier strobe |
| id_ide | input | 1 | 1 = extended-format identifier |
| rx_id | input | 29 | Received identifier (base format uses [10:0]) |
| done | output | 1 | One-cycle result strobe |
| accept | output | 1 | Frame accepted |
| match_idx | output | 8 | Index of the element that hit |
| match_cfg | output | 3 | Action code of the element that hit |

## Verification
The assertions check these properties on every cycle:
- `done` never lasts more than one cycle.
- A strobe in `S_IDLE` always starts a scan.
- The captured identifier stays stable while a scan runs.
- The clamped list size never exceeds its maximum.
- A reported index lies inside the list.
- A reject carries zero index and code.
- A write without permission leaves its word unchanged.

Only the bench scenarios can show the rest, by comparing against a behavioural model: the field layout, the first-hit ordering when several elements match, the skipping of non-classic elements, the exact latency for each index and list size, and the separation between the two lists.

// File: rtl/can_filt_pkg.sv
`timescale 1ns/1ps
package can_filt_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_DONE = 2'd2
    } scan_state_e;

    localparam logic [1:0] TYPE_CLASSIC = 2'd2;
endpackage

// File: rtl/can_filt_mem.sv
`timescale 1ns/1ps
module can_filt_mem #(
    parameter int WORDS = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_permit,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_addr0,
    input  logic [AW-1:0] rd_addr1,
    output logic [31:0]   rd_data0,
    output logic [31:0]   rd_data1
);
    logic [31:0] mem_q [WORDS];
    logic        wr_fire;

    assign wr_fire = wr_en && cfg_permit && (int'(wr_addr) < WORDS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (wr_fire) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data0 = (int'(rd_addr0) < WORDS) ? mem_q[rd_addr0] : '0;
        rd_data1 = (int'(rd_addr1) < WORDS) ? mem_q[rd_addr1] : '0;
    end

    // R2: a write attempt without permission leaves the addressed word intact
    a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_permit && int'(wr_addr) < WORDS)
        |=> (mem_q[$past(wr_addr)] == $past(mem_q[wr_addr])));
endmodule

// File: rtl/can_filt_match.sv
`timescale 1ns/1ps
module can_filt_match
    import can_filt_pkg::*;
(
    input  logic        ide,
    input  logic [28:0] rx_id,
    input  logic [31:0] w0,
    input  logic [31:0] w1,
    output logic        hit,
    output logic [2:0]  cfg
);
    logic unused_bits;
    assign unused_bits = ^{w0[15:11], w1[29]};

    always_comb begin
        if (!ide) begin
            cfg = w0[29:27];
            hit = (w0[31:30] == TYPE_CLASSIC) &&
                  ((rx_id[10:0] & w0[10:0]) == (w0[26:16] & w0[10:0]));
        end else begin
            cfg = w0[31:29];
            hit = (w1[31:30] == TYPE_CLASSIC) &&
                  ((rx_id & w1[28:0]) == (w0[28:0] & w1[28:0]));
        end
    end
endmodule

// File: rtl/can_id_filter.sv
`timescale 1ns/1ps
module can_id_filter
    import can_filt_pkg::*;
#(
    parameter int STD_MAX = 128,
    parameter int EXT_MAX = 64,
    parameter int AW      = $clog2(STD_MAX + 2*EXT_MAX),
    parameter int SCW     = $clog2(STD_MAX + 1),
    parameter int ECW     = $clog2(EXT_MAX + 1),
    parameter int LW      = $clog2(((STD_MAX > EXT_MAX) ? STD_MAX : EXT_MAX) + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_permit,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [31:0]    wr_data,
    input  logic [SCW-1:0] std_count,
    input  logic [ECW-1:0] ext_count,
    input  logic           id_valid,
    input  logic           id_ide,
    input  logic [28:0]    rx_id,
    output logic           done,
    output logic           accept,
    output logic [LW-1:0]  match_idx,
    output logic [2:0]     match_cfg
);
    localparam int WORDS    = STD_MAX + 2*EXT_MAX;
    localparam int EXT_BASE = STD_MAX;

    scan_state_e    state_q, state_d;
    logic [28:0]    id_q;
    logic           ide_q;
    logic [LW-1:0]  idx_q, limit_q, limit_cap;
    logic [AW-1:0]  rd_addr0, rd_addr1;
    logic [31:0]    rd_data0, rd_data1;
    logic           elem_hit, in_range;
    logic [2:0]     elem_cfg;

    can_filt_mem #(.WORDS(WORDS), .AW(AW)) mem_i (
        .clk(clk), .rst_n(rst_n), .cfg_permit(cfg_permit), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr0(rd_addr0), .rd_addr1(rd_addr1),
        .rd_data0(rd_data0), .rd_data1(rd_data1)
    );

    can_filt_match match_i (
        .ide(ide_q), .rx_id(id_q), .w0(rd_data0), .w1(rd_data1),
        .hit(elem_hit), .cfg(elem_cfg)
    );

    always_comb begin
        if (!ide_q) begin
            rd_addr0 = AW'(idx_q);
            rd_addr1 = AW'(idx_q);
        end else begin
            rd_addr0 = AW'(EXT_BASE + 2*int'(idx_q));
            rd_addr1 = AW'(EXT_BASE + 2*int'(idx_q) + 1);
        end
    end

    always_comb begin
        if (id_ide)
            limit_cap = (int'(ext_count) > EXT_MAX) ? LW'(EXT_MAX) : LW'(ext_count);
        else
            limit_cap = (int'(std_count) > STD_MAX) ? LW'(STD_MAX) : LW'(std_count);
    end

    assign in_range = (idx_q < limit_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (id_valid) state_d = S_SCAN;            // START
            S_SCAN: if (!in_range || elem_hit) state_d = S_DONE; // EXHAUST / HIT
            S_DONE: state_d = S_IDLE;                           // RETIRE
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q      <= '0;
            ide_q     <= 1'b0;
            idx_q     <= '0;
            limit_q   <= '0;
            done      <= 1'b0;
            accept    <= 1'b0;
            match_idx <= '0;
            match_cfg <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (id_valid) begin
                        id_q    <= rx_id;
                        ide_q   <= id_ide;
                        idx_q   <= '0;
                        limit_q <= limit_cap;
                    end
                end
                S_SCAN: begin
                    if (!in_range) begin
                        done      <= 1'b1;
                        accept    <= 1'b0;
                        match_idx <= '0;
                        match_cfg <= '0;
                    end else if (elem_hit) begin
                        done      <= 1'b1;
                        accept    <= 1'b1;
                        match_idx <= idx_q;
                        match_cfg <= elem_cfg;
                    end else begin
                        idx_q <= idx_q + 1'b1;                  // NEXT
                    end
                end
                S_DONE: done <= 1'b0;
                default: done <= 1'b0;
            endcase
        end
    end

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_scan_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && id_valid) |=> (state_q == S_SCAN));
    a_r7_reject_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accept) |-> (match_idx == '0 && match_cfg == '0));
    a_r6_idx_in_list: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept) |-> (match_idx < limit_q));
    a_r9_limit_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> (limit_q <= (ide_q ? LW'(EXT_MAX) : LW'(STD_MAX))));
    a_r10_id_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN) |=> $stable(id_q));
endmodule

// File: tb/can_id_filter_tb.sv
`timescale 1ns/1ps
module can_id_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_permit = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  std_count = '0;
    logic [6:0]  ext_count = '0;
    logic        id_valid = 1'b0;
    logic        id_ide = 1'b0;
    logic [28:0] rx_id = '0;
    logic        done, accept;
    logic [7:0]  match_idx;
    logic [2:0]  match_cfg;

    can_id_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_permit(cfg_permit), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .std_count(std_count),
        .ext_count(ext_count), .id_valid(id_valid), .id_ide(id_ide),
        .rx_id(rx_id), .done(done), .accept(accept),
        .match_idx(match_idx), .match_cfg(match_cfg)
    );

    always #4 clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    checking = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    // behavioural reference
    logic [31:0] mirror [256];
    bit m_busy = 0, m_done = 0, m_acc = 0;
    int m_rem = 0, m_idx = 0, m_cfg = 0;
    bit p_acc; int p_idx, p_cfg;

    initial for (int i = 0; i < 256; i++) mirror[i] = '0;

    function automatic void ref_eval(input bit ide, input logic [28:0] id, input int cnt,
                                     output bit acc, output int idx, output int cfg,
                                     output int lat);
        int lim;
        lim = ide ? ((cnt > 64) ? 64 : cnt) : ((cnt > 128) ? 128 : cnt);
        acc = 0; idx = 0; cfg = 0; lat = 1 + lim;
        for (int n = 0; n < lim; n++) begin
            logic [31:0] a, b;
            bit h;
            if (!ide) begin
                a = mirror[n];
                h = (a[31:30] == 2'd2) && ((id[10:0] & a[10:0]) == (a[26:16] & a[10:0]));
                if (h) begin acc = 1; idx = n; cfg = int'(a[29:27]); lat = 1 + n; break; end
            end else begin
                a = mirror[128 + 2*n];
                b = mirror[128 + 2*n + 1];
                h = (b[31:30] == 2'd2) && ((id & b[28:0]) == (a[28:0] & b[28:0]));
                if (h) begin acc = 1; idx = n; cfg = int'(a[31:29]); lat = 1 + n; break; end
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_acc = 0; m_idx = 0; m_cfg = 0;
            for (int i = 0; i < 256; i++) mirror[i] = '0;
        end else begin
            if (cfg_permit && wr_en) mirror[wr_addr] = wr_data;
            if (m_done) begin
                m_done = 0; m_busy = 0;
            end else if (m_busy) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    m_done = 1; m_acc = p_acc; m_idx = p_idx; m_cfg = p_cfg;
                end
            end else if (id_valid) begin
                int lat;
                ref_eval(id_ide, rx_id, id_ide ? int'(ext_count) : int'(std_count),
                         p_acc, p_idx, p_cfg, lat);
                m_busy = 1; m_rem = lat;
            end
        end
    end

    always @(negedge clk) begin
        if (checking && !finished) begin
            n_tests++;
            if (done !== m_done) begin
                n_fail++;
                $display("FAIL R8 done=%0b expected %0b (scenario %s)", done, m_done, cur_tag);
            end else if (accept !== m_acc || int'(match_idx) != m_idx || int'(match_cfg) != m_cfg) begin
                n_fail++;
                $display("FAIL %s acc/idx/cfg=%0b/%0d/%0d expected %0b/%0d/%0d",
                         cur_tag, accept, match_idx, match_cfg, m_acc, m_idx, m_cfg);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic send(input bit ide, input logic [28:0] id, input string tag);
        @(negedge clk); cur_tag = tag; id_valid = 1; id_ide = ide; rx_id = id;
        @(negedge clk); id_valid = 0;
        while (m_busy || m_done) @(negedge clk);
    endtask

    function automatic logic [31:0] std_el(input int t, input int c, input int id, input int mk);
        return {t[1:0], c[2:0], id[10:0], 5'd0, mk[10:0]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;
        if (done !== 0 || accept !== 0 || match_idx !== 0 || match_cfg !== 0) begin
            n_fail++;
            $display("FAIL R1 reset outputs %0b/%0b/%0d/%0d expected 0/0/0/0",
                     done, accept, match_idx, match_cfg);
        end
        rst_n = 1;
        checking = 1;
        // base list (R3, R5, R11)
        cfg_permit = 1;
        wr(8'd0, std_el(2, 4, 'h123, 'h7FF));
        wr(8'd1, std_el(1, 3, 'h055, 'h000));
        wr(8'd2, std_el(2, 1, 'h050, 'h7F0));
        wr(8'd3, std_el(2, 4, 'h000, 'h000));
        cfg_permit = 0;
        std_count = 8'd3;
        send(0, 29'h123, "R3");
        send(0, 29'h055, "R5");
        send(0, 29'h200, "R7");
        std_count = 8'd4;
        send(0, 29'h200, "R6");
        send(0, 29'h123, "R6");
        std_count = 8'd0;
        send(0, 29'h123, "R7");
        // R2: write without permission is dropped
        wr(8'd0, 32'h0);
        std_count = 8'd1;
        send(0, 29'h123, "R2");
        // extended list (R4, R11)
        cfg_permit = 1;
        wr(8'd128, {3'd4, 29'h1ABCDE01});
        wr(8'd129, {2'd2, 1'b0, 29'h1FFFFFFF});
        wr(8'd130, {3'd2, 29'h00000123});
        wr(8'd131, {2'd2, 1'b0, 29'h000007FF});
        wr(8'd3, 32'h0);
        wr(8'd127, std_el(2, 5, 'h3AA, 'h7FF));
        cfg_permit = 0;
        ext_count = 7'd2;
        send(1, 29'h1ABCDE01, "R4");
        send(1, 29'h0F000123, "R11");
        std_count = 8'd4;
        send(0, 29'h123, "R9");
        send(1, 29'h1ABCDE02, "R7");
        // clamps (R9)
        ext_count = 7'd100;
        send(1, 29'h00000456, "R9");
        std_count = 8'd200;
        send(0, 29'h3AA, "R9");
        std_count = 8'd255;
        send(0, 29'h3AB, "R9");
        // R10: strobe during a scan is ignored
        std_count = 8'd200;
        @(negedge clk); cur_tag = "R10"; id_valid = 1; id_ide = 0; rx_id = 29'h3AA;
        @(negedge clk); id_valid = 0;
        repeat (5) @(negedge clk);
        id_valid = 1; rx_id = 29'h123;
        @(negedge clk); id_valid = 0;
        while (m_busy || m_done) @(negedge clk);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired (scenario %s)", cur_tag);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule